// File: doc/BRIEF.md
# SD Host Programmed-I/O Buffer Port

This block sits between a 32-bit register bus and the block buffer of an SD host controller and carries programmed-I/O data. Software moves data one, two or four bytes at a time through a single 32-bit port word. Bytes are packed least significant first. A running byte position inside the current block is kept. An access is taken only if its byte lane continues that position exactly, and only while the buffer is in the right state for its direction.

The card side of the controller lies outside this block. It loads the buffer through a byte fill port, reads it back through a byte peek port, and announces a full read buffer or an empty write buffer with single-cycle set pulses. Each set pulse raises an availability flag and a one-cycle buffer-ready pulse. When a whole block has passed through the port, the block clears the flag by itself and returns the position to zero. A drained read block that still has blocks behind it raises a refill request. A filled write block raises a flush request and holds a busy status until the card side acknowledges it.

Top module: `sdbuf_port`

## Requirements
- R1: A read access while `data_avail` is low is refused: `acc_ok` stays 0, `rd_data` is 0, and the byte position and the flags keep their values.
- R2: A write access while `space_avail` is low is refused and does not change any buffer byte.
- R3: An access is taken only when `acc_lane` equals the byte position modulo 4, the access fits in the port word (lane plus byte count at most 4), and the size code is not 3. A refused read returns 0.
- R4: Size code 0, 1 and 2 moves 1, 2 and 4 bytes. The byte at the current position travels in `rd_data[7:0]` or `acc_wdata[7:0]`, and the following bytes travel in the next higher bytes. Unused high bytes of `rd_data` are 0.
- R5: Each byte moved advances the position by one. When the position reaches `blk_len` (1 to buffer depth), it returns to 0 and the flag for that direction clears. Bytes of the same access that lie past the block end are dropped on a write and read as 0.
- R6: A `set_data` pulse sets `data_avail` and gives a one-cycle `rd_rdy`. A `set_space` pulse sets `space_avail` and gives a one-cycle `wr_rdy`.
- R7: When a read block drains with `blk_cnt` above 1, `refill_req` pulses for one cycle and `blk_cnt` drops by one. With `blk_cnt` at 1 or below, there is no request and no change.
- R8: When a write block fills, `flush_req` pulses for one cycle and `wr_busy` rises. `wr_busy` stays high until `flush_ack`.
- R9: `soft_rst` returns the position to 0 and clears both availability flags.
- R10: The buffer holds 1 << (9 + MAX_BLK_CODE) bytes, 512 by default. The card side reaches it through `fill_we`/`fill_addr`/`fill_byte` and through the combinational `peek_addr`/`peek_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset of position and flags |
| blk_len | input | 12 | Block length in bytes |
| cnt_load | input | 1 | Load the block count |
| cnt_val | input | 16 | Block count to load |
| blk_cnt | output | 16 | Remaining block count |
| acc_valid | input | 1 | Port access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_lane | input | 2 | Byte offset of the access in the port word |
| acc_size | input | 2 | 0/1/2 = 1/2/4 bytes |
| acc_wdata | input | 32 | Write data, first byte in [7:0] |
| acc_ok | output | 1 | Previous access was taken |
| rd_data | output | 32 | Read data of the previous access |
| set_data | input | 1 | Read buffer has been loaded |
| set_space | input | 1 | Write buffer is free |
| data_avail | output | 1 | Read data available |
| space_avail | output | 1 | Write space available |
| rd_rdy | output | 1 | Read buffer-ready pulse |
| wr_rdy | output | 1 | Write buffer-ready pulse |
| refill_req | output | 1 | Request to load the next read block |
| flush_req | output | 1 | Request to send the written block |
| flush_ack | input | 1 | Flush done |
| wr_busy | output | 1 | Flush outstanding |
| fill_we | input | 1 | Card-side byte write enable |
| fill_addr | input | 9 | Card-side write address |
| fill_byte | input | 8 | Card-side write byte |
| peek_addr | input | 9 | Card-side read address |
| peek_byte | output | 8 | Card-side read byte, combinational |

## Verification
Every registered result is due one edge after its stimulus. This covers `acc_ok`, `rd_data`, the flags, the ready pulses, `refill_req`, `flush_req`, `blk_cnt` and `wr_busy`. Only `peek_byte` is combinational and is due in the same cycle. The bench drives inputs on the falling edge, so exactly one rising edge passes between the stimulus and the next falling edge, and it samples there. One-cycle pulses are therefore seen exactly once. Each `peek_byte` read is sampled shortly after `peek_addr` is set.

// File: rtl/sdbuf_port.sv
module sdbuf_port #(
  parameter int MAX_BLK_CODE = 0,
  parameter int LW  = 12,
  parameter int BCW = 16,
  localparam int AW = 9 + MAX_BLK_CODE,
  localparam int DEPTH = 1 << AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic [LW-1:0]  blk_len,
  input  logic           cnt_load,
  input  logic [BCW-1:0] cnt_val,
  output logic [BCW-1:0] blk_cnt,
  input  logic           acc_valid,
  input  logic           acc_write,
  input  logic [1:0]     acc_lane,
  input  logic [1:0]     acc_size,
  input  logic [31:0]    acc_wdata,
  output logic           acc_ok,
  output logic [31:0]    rd_data,
  input  logic           set_data,
  input  logic           set_space,
  output logic           data_avail,
  output logic           space_avail,
  output logic           rd_rdy,
  output logic           wr_rdy,
  output logic           refill_req,
  output logic           flush_req,
  input  logic           flush_ack,
  output logic           wr_busy,
  input  logic           fill_we,
  input  logic [AW-1:0]  fill_addr,
  input  logic [7:0]     fill_byte,
  input  logic [AW-1:0]  peek_addr,
  output logic [7:0]     peek_byte
);
  localparam logic [BCW-1:0] CNT_ONE = BCW'(1);

  logic [7:0]    mem [DEPTH];
  logic [LW-1:0] pos;
  logic [2:0]    nb;
  logic          fits, flag_ok, go, done;
  logic [3:0]    bv;
  logic [2:0]    take;
  logic [LW-1:0] next_pos;
  logic [AW-1:0] baddr [4];
  logic [7:0]    rbyte [4];

  assign nb      = (acc_size == 2'd0) ? 3'd1 : (acc_size == 2'd1) ? 3'd2 : 3'd4;
  assign fits    = ({1'b0, acc_lane} + nb) <= 3'd4;
  assign flag_ok = acc_write ? space_avail : data_avail;
  assign go      = acc_valid && flag_ok && (acc_lane == pos[1:0]) && fits && (acc_size != 2'd3);
  assign peek_byte = mem[peek_addr];

  always_comb begin
    take = 3'd0;
    for (int i = 0; i < 4; i++) begin
      bv[i]    = (3'(i) < nb) && (({1'b0, pos} + (LW+1)'(i)) < {1'b0, blk_len});
      baddr[i] = AW'(pos + LW'(i));
      rbyte[i] = bv[i] ? mem[baddr[i]] : 8'h00;
      take     = take + {2'b00, bv[i]};
    end
  end

  assign next_pos = pos + LW'(take);
  assign done     = next_pos >= blk_len;

  always_ff @(posedge clk) begin
    if (fill_we) mem[fill_addr] <= fill_byte;
    if (rst_n && !soft_rst && go && acc_write)
      for (int i = 0; i < 4; i++)
        if (bv[i]) mem[baddr[i]] <= acc_wdata[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0; data_avail <= 1'b0; space_avail <= 1'b0;
      acc_ok <= 1'b0; rd_data <= '0; rd_rdy <= 1'b0; wr_rdy <= 1'b0;
      refill_req <= 1'b0; flush_req <= 1'b0; wr_busy <= 1'b0; blk_cnt <= '0;
    end else begin
      acc_ok <= 1'b0; rd_data <= '0; rd_rdy <= 1'b0; wr_rdy <= 1'b0;
      refill_req <= 1'b0; flush_req <= 1'b0;
      if (flush_ack) wr_busy <= 1'b0;
      if (cnt_load) blk_cnt <= cnt_val;
      if (soft_rst) begin
        pos <= '0; data_avail <= 1'b0; space_avail <= 1'b0;
      end else begin
        if (go) begin
          acc_ok <= 1'b1;
          if (!acc_write) rd_data <= {rbyte[3], rbyte[2], rbyte[1], rbyte[0]};
          pos <= done ? '0 : next_pos;
          if (done) begin
            if (acc_write) begin
              space_avail <= 1'b0; flush_req <= 1'b1; wr_busy <= 1'b1;
            end else begin
              data_avail <= 1'b0;
              if (blk_cnt > CNT_ONE) begin
                refill_req <= 1'b1;
                if (!cnt_load) blk_cnt <= blk_cnt - CNT_ONE;
              end
            end
          end
        end
        if (set_data)  begin data_avail  <= 1'b1; rd_rdy <= 1'b1; end
        if (set_space) begin space_avail <= 1'b1; wr_rdy <= 1'b1; end
      end
    end
  end

  a_r1_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write && !data_avail |=> !acc_ok && rd_data == '0);
  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && !space_avail |=> !acc_ok);
  a_r3_lane_check: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && (acc_lane != pos[1:0]) |=> !acc_ok && rd_data == '0);
  a_r5_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_avail) |-> $past(soft_rst) || $past(acc_valid && !acc_write));
  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    set_data && !soft_rst |=> rd_rdy && data_avail);
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req && !$past(cnt_load) |-> blk_cnt == $past(blk_cnt) - CNT_ONE);
  a_r8_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> wr_busy);
  a_r9_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !data_avail && !space_avail);
endmodule

// File: tb/test_sdbuf_port.sv
`timescale 1ns/1ps
module test_sdbuf_port;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, soft_rst, cnt_load, acc_valid, acc_write, set_data, set_space;
  logic flush_ack, fill_we;
  logic [11:0] blk_len;
  logic [15:0] cnt_val, blk_cnt;
  logic [1:0]  acc_lane, acc_size;
  logic [31:0] acc_wdata, rd_data;
  logic acc_ok, data_avail, space_avail, rd_rdy, wr_rdy, refill_req, flush_req, wr_busy;
  logic [8:0] fill_addr, peek_addr;
  logic [7:0] fill_byte, peek_byte;

  sdbuf_port i_sdbuf_port (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .blk_len(blk_len),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .blk_cnt(blk_cnt),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_lane(acc_lane),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_ok(acc_ok), .rd_data(rd_data),
    .set_data(set_data), .set_space(set_space), .data_avail(data_avail),
    .space_avail(space_avail), .rd_rdy(rd_rdy), .wr_rdy(wr_rdy),
    .refill_req(refill_req), .flush_req(flush_req), .flush_ack(flush_ack),
    .wr_busy(wr_busy), .fill_we(fill_we), .fill_addr(fill_addr),
    .fill_byte(fill_byte), .peek_addr(peek_addr), .peek_byte(peek_byte));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rpat(int a, int s, int l);
    return 8'((a * 37 + s * 11 + l) & 255);
  endfunction
  function automatic logic [7:0] wpat(int a, int s, int l);
    return 8'((a * 53 + s * 5 + l * 3 + 1) & 255);
  endfunction

  task automatic access(input bit w, input logic [1:0] ln, input logic [1:0] sz, input logic [31:0] wd);
    acc_valid = 1'b1; acc_write = w; acc_lane = ln; acc_size = sz; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic fill(input int a, input logic [7:0] b);
    fill_we = 1'b1; fill_addr = 9'(a); fill_byte = b;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic peek(input int a, output logic [7:0] b);
    peek_addr = 9'(a);
    #0.5 b = peek_byte;
  endtask

  task automatic load_cnt(input int v);
    cnt_load = 1'b1; cnt_val = 16'(v);
    @(negedge clk);
    cnt_load = 1'b0;
  endtask

  task automatic read_pass(input int sz, input int L, input int cnt);
    int p;
    fill(L, 8'h00);
    for (int a = 0; a < L; a++) fill(a, rpat(a, sz, L));
    blk_len = 12'(L);
    load_cnt(cnt);
    set_data = 1'b1; @(negedge clk); set_data = 1'b0;
    chk("R6 rd_rdy", {31'b0, rd_rdy}, 32'd1);
    chk("R6 data_avail", {31'b0, data_avail}, 32'd1);
    p = 0;
    while (p < L) begin
      int ln, n, s, c;
      logic [31:0] e;
      ln = p % 4; s = sz; n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      if (ln + n > 4) begin s = 0; n = 1; end
      if (p == 1) begin
        access(1'b0, 2'((ln + 1) % 4), 2'd0, 32'h0);
        chk("R3 wrong lane ok", {31'b0, acc_ok}, 32'd0);
        chk("R3 wrong lane data", rd_data, 32'd0);
      end
      e = 32'h0; c = 0;
      for (int i = 0; i < n; i++)
        if (p + i < L) begin e[8*i +: 8] = rpat(p + i, sz, L); c++; end
      access(1'b0, 2'(ln), 2'(s), 32'h0);
      chk("R4 read ok", {31'b0, acc_ok}, 32'd1);
      chk("R4 read data", rd_data, e);
      p += c;
      chk("R5 data flag", {31'b0, data_avail}, (p >= L) ? 32'd0 : 32'd1);
      if (p >= L) begin
        chk("R7 refill", {31'b0, refill_req}, (cnt > 1) ? 32'd1 : 32'd0);
        chk("R7 blk_cnt", {16'b0, blk_cnt}, 32'((cnt > 1) ? cnt - 1 : cnt));
      end
    end
    @(negedge clk);
    chk("R7 refill single", {31'b0, refill_req}, 32'd0);
    access(1'b0, 2'd0, 2'd0, 32'h0);
    chk("R1 empty read ok", {31'b0, acc_ok}, 32'd0);
    chk("R1 empty read data", rd_data, 32'd0);
    chk("R1 flags kept", {30'b0, data_avail, space_avail}, 32'd0);
  endtask

  task automatic write_pass(input int sz, input int L);
    int p;
    logic [7:0] b;
    blk_len = 12'(L);
    fill(L, 8'h5A);
    set_space = 1'b1; @(negedge clk); set_space = 1'b0;
    chk("R6 wr_rdy", {31'b0, wr_rdy}, 32'd1);
    chk("R6 space_avail", {31'b0, space_avail}, 32'd1);
    p = 0;
    while (p < L) begin
      int ln, n, s, c;
      logic [31:0] wd;
      ln = p % 4; s = sz; n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      if (ln + n > 4) begin s = 0; n = 1; end
      wd = 32'hEEEEEEEE; c = 0;
      for (int i = 0; i < n; i++)
        if (p + i < L) begin wd[8*i +: 8] = wpat(p + i, sz, L); c++; end
      access(1'b1, 2'(ln), 2'(s), wd);
      chk("R4 write ok", {31'b0, acc_ok}, 32'd1);
      p += c;
      chk("R5 space flag", {31'b0, space_avail}, (p >= L) ? 32'd0 : 32'd1);
      if (p >= L) begin
        chk("R8 flush_req", {31'b0, flush_req}, 32'd1);
        chk("R8 busy", {31'b0, wr_busy}, 32'd1);
      end
    end
    for (int a = 0; a < L; a++) begin
      peek(a, b);
      chk("R4 written byte", {24'b0, b}, {24'b0, wpat(a, sz, L)});
    end
    peek(L, b);
    chk("R5 byte past block", {24'b0, b}, 32'h5A);
    @(negedge clk);
    chk("R8 flush single", {31'b0, flush_req}, 32'd0);
    chk("R8 busy held", {31'b0, wr_busy}, 32'd1);
    access(1'b1, 2'd0, 2'd0, 32'h000000C3);
    chk("R2 full write ok", {31'b0, acc_ok}, 32'd0);
    peek(0, b);
    chk("R2 byte unchanged", {24'b0, b}, {24'b0, wpat(0, sz, L)});
    flush_ack = 1'b1; @(negedge clk); flush_ack = 1'b0;
    chk("R8 busy cleared", {31'b0, wr_busy}, 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    rst_n = 0; soft_rst = 0; cnt_load = 0; cnt_val = 0; acc_valid = 0; acc_write = 0;
    acc_lane = 0; acc_size = 0; acc_wdata = 0; set_data = 0; set_space = 0;
    flush_ack = 0; fill_we = 0; fill_addr = 0; fill_byte = 0; peek_addr = 0; blk_len = 12'd8;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset flags", {28'b0, data_avail, space_avail, wr_busy, acc_ok}, 32'd0);
    chk("reset blk_cnt", {16'b0, blk_cnt}, 32'd0);

    foreach (b[k]) ;
    for (int sz = 0; sz < 3; sz++)
      for (int li = 0; li < 4; li++) begin
        int L;
        L = (li == 0) ? 3 : (li == 1) ? 5 : (li == 2) ? 8 : 13;
        read_pass(sz, L, 2);
        write_pass(sz, L);
      end
    read_pass(2, 4, 1);

    access(1'b0, 2'd0, 2'd3, 32'h0);
    chk("R3 size code 3", {31'b0, acc_ok}, 32'd0);

    fill(511, 8'hA7);
    peek(511, b);
    chk("R10 top byte", {24'b0, b}, 32'hA7);

    blk_len = 12'd8;
    for (int a = 0; a < 8; a++) fill(a, 8'(a + 16));
    set_data = 1'b1; @(negedge clk); set_data = 1'b0;
    access(1'b0, 2'd0, 2'd0, 32'h0);
    chk("R9 pre read", rd_data, 32'h10);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    chk("R9 flags cleared", {30'b0, data_avail, space_avail}, 32'd0);
    set_data = 1'b1; @(negedge clk); set_data = 1'b0;
    access(1'b0, 2'd0, 2'd1, 32'h0);
    chk("R9 position zero ok", {31'b0, acc_ok}, 32'd1);
    chk("R9 position zero data", rd_data, 32'h1110);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule